// File: doc/BRIEF.md
# Multicycle Accumulator Processor Core

This block is a small stored-program processor. Instructions and data share one synchronous single-port memory. Every instruction goes through three phases: fetch, decode and execute. Each memory access passes through two registers. An address register (MAR) drives the memory address. A data register (MDR) captures read data or holds the word to be written. The core keeps a program counter, an instruction register, an 8-bit accumulator and one 8-bit general register X.

A memory word is 16 bits wide:
- Bits 15:8 hold the opcode.
- Bits 7:0 hold the operand, which is an address or a jump target.
- The least significant opcode bit selects indirect addressing for the two load instructions.

The instruction set is:
- Load accumulator and load X, each either direct or through one level of indirection.
- Subtract X from the accumulator.
- Store the accumulator.
- Jump when the accumulator is zero or negative.

Any other opcode stops the core and raises a halt output. The memory outside the core returns read data one clock after the address, and it commits a write on the clock edge where the write enable is high.

Top module: `acc_cpu_core`

## Requirements
- R1: During reset `mem_addr` is 0, `mem_we` is 0 and `halt` is 0. After reset the first instruction is fetched from address `RESET_VEC` (default 0x05).
- R2: Fetch takes four cycles. In cycle 1 the MAR is loaded from the PC. In cycle 2 the memory read is issued. In cycle 3 the read data goes into the MDR. In cycle 4 the MDR goes into the IR. From cycle 2 onward `mem_addr` equals the fetch address.
- R3: Decode is cycle 5. The opcode is taken from IR bits 15:8 and the operand from bits 7:0, and the PC advances by exactly one. The defined opcodes are 0x10, 0x11, 0x30, 0x31, 0x20, 0x50 and 0x90.
- R4: Opcode 0x10 (direct load of the accumulator) drives the operand on `mem_addr` from cycle 7. It loads the accumulator with bits 7:0 of the addressed word and ignores bits 15:8. The instruction takes 9 cycles.
- R5: Opcodes 0x11 and 0x31 (indirect loads) read the operand's word first. Its bits 7:0 then go through MDR and MAR as a second address, and the data comes from that address. `mem_addr` shows the second address from cycle 10, and the instruction takes 12 cycles.
- R6: Opcode 0x30 loads X. A load of X leaves the accumulator unchanged, and a load of the accumulator leaves X unchanged.
- R7: Opcode 0x20 sets the accumulator to accumulator minus X, modulo 256, in two's complement. The instruction takes 6 cycles.
- R8: Opcode 0x90 loads the operand into the PC when accumulator bit 7 is set or the accumulator is zero. Otherwise the incremented PC is kept. The instruction takes 6 cycles.
- R9: Opcode 0x50 places the operand in the MAR and {8'h00, accumulator} in the MDR. It then raises `mem_we` for exactly one cycle (cycle 8), which overwrites the old word. The instruction takes 8 cycles.
- R10: Any other opcode (for example 0x40, 0x21, 0x51 or 0x91) raises `halt` from cycle 6. The core then stays halted, with no further writes and `mem_addr` held, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 8 | Memory address, driven from the MAR |
| mem_wdata | output | 16 | Memory write data, driven from the MDR |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 16 | Memory read data, valid one cycle after the address |
| halt | output | 1 | High once an undefined opcode has been decoded |

## Verification
Cycle 1 of an instruction is the first cycle in which the state machine loads the MAR from the PC. Relative to that cycle:
- The fetch address appears in cycle 2.
- A direct operand address appears in cycle 7, and an indirect target in cycle 10.
- A store's write enable appears in cycle 8, and halt in cycle 6.
- The next instruction starts after 6, 8, 9 or 12 cycles, depending on the opcode.

The bench builds the expected port values for every cycle from an instruction-level model that applies these counts. It compares address, write enable, write data and halt at each falling edge, and then checks the final memory contents.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    typedef enum logic [3:0] {
        ST_FADDR, ST_FWAIT, ST_FCAP, ST_IR, ST_DEC,
        ST_OADDR, ST_OWAIT, ST_OCAP, ST_IADDR, ST_WB,
        ST_ALU, ST_JMP, ST_SADDR, ST_SDATA, ST_SWR, ST_HALT
    } state_e;

    typedef enum logic [2:0] {
        K_LDA, K_LDX, K_SUB, K_STA, K_JLE, K_BAD
    } kind_e;

    localparam logic [7:0] OPC_LDA = 8'h10;
    localparam logic [7:0] OPC_SUB = 8'h20;
    localparam logic [7:0] OPC_LDX = 8'h30;
    localparam logic [7:0] OPC_STA = 8'h50;
    localparam logic [7:0] OPC_JLE = 8'h90;

endpackage

// File: rtl/acc_cpu_decode.sv
module acc_cpu_decode
    import acc_cpu_pkg::*;
#(
    parameter int OP_W = 8
) (
    input  logic [OP_W-1:0] opcode,
    output kind_e           kind,
    output logic            indirect
);
    logic [OP_W-1:0] base;

    always_comb begin
        // the low opcode bit is the indirect flag; the rest names the operation
        base     = {opcode[OP_W-1:1], 1'b0};
        indirect = opcode[0];
        kind     = K_BAD;
        if (base == OP_W'(OPC_LDA))      kind = K_LDA;
        else if (base == OP_W'(OPC_LDX)) kind = K_LDX;
        else if (opcode == OP_W'(OPC_SUB)) kind = K_SUB;
        else if (opcode == OP_W'(OPC_STA)) kind = K_STA;
        else if (opcode == OP_W'(OPC_JLE)) kind = K_JLE;
        else kind = K_BAD;
    end
endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] xval,
    output logic [DATA_W-1:0] diff,
    output logic              le_zero
);
    always_comb begin
        diff    = acc - xval;
        le_zero = acc[DATA_W-1] | (acc == '0);
    end
endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core
    import acc_cpu_pkg::*;
#(
    parameter int               ADDR_W    = 8,
    parameter int               OP_W      = 8,
    parameter logic [ADDR_W-1:0] RESET_VEC = 8'h05
) (
    input  logic                   clk,
    input  logic                   rst_n,
    output logic [ADDR_W-1:0]      mem_addr,
    output logic [OP_W+ADDR_W-1:0] mem_wdata,
    output logic                   mem_we,
    input  logic [OP_W+ADDR_W-1:0] mem_rdata,
    output logic                   halt
);
    localparam int WORD_W = OP_W + ADDR_W;
    localparam int DATA_W = ADDR_W;

    typedef struct packed {
        state_e              st;
        logic [ADDR_W-1:0]   pc;
        logic [ADDR_W-1:0]   mar;
        logic [WORD_W-1:0]   mdr;
        logic [WORD_W-1:0]   ir;
        logic [DATA_W-1:0]   acc;
        logic [DATA_W-1:0]   xr;
        logic                ind;
    } regs_t;

    regs_t r_q, r_d;

    kind_e             kind;
    logic              ind_sel;
    logic [DATA_W-1:0] diff;
    logic              le_zero;
    logic [ADDR_W-1:0] operand;

    assign operand = r_q.ir[ADDR_W-1:0];

    acc_cpu_decode #(.OP_W(OP_W)) i_dec (
        .opcode   (r_q.ir[WORD_W-1:ADDR_W]),
        .kind     (kind),
        .indirect (ind_sel)
    );

    acc_cpu_alu #(.DATA_W(DATA_W)) i_alu (
        .acc     (r_q.acc),
        .xval    (r_q.xr),
        .diff    (diff),
        .le_zero (le_zero)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_FADDR: begin r_d.mar = r_q.pc; r_d.st = ST_FWAIT; end
            ST_FWAIT: r_d.st = ST_FCAP;
            ST_FCAP:  begin r_d.mdr = mem_rdata; r_d.st = ST_IR; end
            ST_IR:    begin r_d.ir = r_q.mdr; r_d.st = ST_DEC; end
            ST_DEC: begin
                r_d.pc  = r_q.pc + ADDR_W'(1);
                r_d.ind = ind_sel;
                case (kind)
                    K_LDA, K_LDX: r_d.st = ST_OADDR;
                    K_SUB:        r_d.st = ST_ALU;
                    K_JLE:        r_d.st = ST_JMP;
                    K_STA:        r_d.st = ST_SADDR;
                    default:      r_d.st = ST_HALT;
                endcase
            end
            ST_OADDR: begin r_d.mar = operand; r_d.st = ST_OWAIT; end
            ST_OWAIT: r_d.st = ST_OCAP;
            ST_OCAP: begin
                r_d.mdr = mem_rdata;
                r_d.st  = r_q.ind ? ST_IADDR : ST_WB;
            end
            ST_IADDR: begin
                r_d.mar = r_q.mdr[ADDR_W-1:0];
                r_d.ind = 1'b0;
                r_d.st  = ST_OWAIT;
            end
            ST_WB: begin
                if (kind == K_LDX) r_d.xr  = r_q.mdr[DATA_W-1:0];
                else               r_d.acc = r_q.mdr[DATA_W-1:0];
                r_d.st = ST_FADDR;
            end
            ST_ALU: begin r_d.acc = diff; r_d.st = ST_FADDR; end
            ST_JMP: begin
                if (le_zero) r_d.pc = operand;
                r_d.st = ST_FADDR;
            end
            ST_SADDR: begin r_d.mar = operand; r_d.st = ST_SDATA; end
            ST_SDATA: begin r_d.mdr = {{OP_W{1'b0}}, r_q.acc}; r_d.st = ST_SWR; end
            ST_SWR:   r_d.st = ST_FADDR;
            ST_HALT:  r_d.st = ST_HALT;
            default:  r_d.st = ST_HALT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q     <= '0;
            r_q.st  <= ST_FADDR;
            r_q.pc  <= RESET_VEC;
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_addr  = r_q.mar;
    assign mem_wdata = r_q.mdr;
    assign mem_we    = (r_q.st == ST_SWR);
    assign halt      = (r_q.st == ST_HALT);

    // R2
    fetch_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_FCAP) |-> (mem_addr == r_q.pc));

    // R3
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_DEC) |=> (r_q.pc == $past(r_q.pc) + ADDR_W'(1)));

    // R4
    lda_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_WB && kind == K_LDA) |=> (r_q.acc == $past(r_q.mdr[DATA_W-1:0])));

    // R6
    ldx_keeps_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_WB && kind == K_LDX) |=> $stable(r_q.acc));

    // R8
    jle_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_JMP && le_zero) |=> (r_q.pc == $past(operand)));

    // R8
    jle_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_JMP && !le_zero) |=> $stable(r_q.pc));

    // R9
    store_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_wdata == {{OP_W{1'b0}}, r_q.acc}) && (mem_addr == operand));

    // R9
    store_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    // R10
    halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> halt && !mem_we && $stable(mem_addr));

endmodule

// File: tb/test_acc_cpu_core.sv
module test_acc_cpu_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  mem_addr;
    logic [15:0] mem_wdata;
    logic        mem_we;
    logic [15:0] mem_rdata = 16'h0;
    logic        halt;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [15:0] ram [256];
    logic [15:0] mm  [256];

    logic [7:0]  q_addr [$];
    bit          q_we   [$];
    logic [15:0] q_wd   [$];
    bit          q_halt [$];
    string       q_tag  [$];

    always #10 clk = ~clk;

    acc_cpu_core i_acc_cpu_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .mem_rdata (mem_rdata),
        .halt      (halt)
    );

    always @(posedge clk) begin
        if (mem_we) ram[mem_addr] <= mem_wdata;
        mem_rdata <= ram[mem_addr];
    end

    task automatic push(input logic [7:0] a, input bit we, input logic [15:0] wd,
                        input bit h, input string tag);
        q_addr.push_back(a); q_we.push_back(we); q_wd.push_back(wd);
        q_halt.push_back(h); q_tag.push_back(tag);
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic build_trace;
        logic [7:0]  pc, mar, acc, xr, op, od;
        logic [15:0] w;
        pc = 8'h05; mar = 8'h00; acc = 8'h00; xr = 8'h00;
        for (int n = 0; n < 100; n++) begin
            w = mm[pc]; op = w[15:8]; od = w[7:0];
            push(mar, 0, 16'h0, 0, "R2");
            mar = pc;
            repeat (3) push(mar, 0, 16'h0, 0, "R2");
            push(mar, 0, 16'h0, 0, "R3");
            pc = pc + 8'h01;
            case (op)
                8'h10, 8'h11, 8'h30, 8'h31: begin
                    push(mar, 0, 16'h0, 0, "R4");
                    mar = od;
                    repeat (3) push(mar, 0, 16'h0, 0, "R4");
                    if (op[0]) begin
                        mar = mm[od][7:0];
                        repeat (3) push(mar, 0, 16'h0, 0, "R5");
                    end
                    if (op[5]) xr = mm[mar][7:0];
                    else       acc = mm[mar][7:0];
                end
                8'h20: begin push(mar, 0, 16'h0, 0, "R7"); acc = acc - xr; end
                8'h90: begin
                    push(mar, 0, 16'h0, 0, "R8");
                    if (acc[7] || acc == 8'h00) pc = od;
                end
                8'h50: begin
                    push(mar, 0, 16'h0, 0, "R9");
                    mar = od;
                    push(mar, 0, 16'h0, 0, "R9");
                    push(mar, 1, {8'h00, acc}, 0, "R9");
                    mm[od] = {8'h00, acc};
                end
                default: begin
                    repeat (12) push(mar, 0, 16'h0, 1, "R10");
                    return;
                end
            endcase
        end
    endtask

    initial begin
        for (int a = 0; a < 256; a++) ram[a] = 16'h0000;
        ram[8'h05] = 16'h1040; ram[8'h06] = 16'h3141; ram[8'h07] = 16'h2000;
        ram[8'h08] = 16'h900A; ram[8'h09] = 16'hFF00; ram[8'h0A] = 16'h5043;
        ram[8'h0B] = 16'h3044; ram[8'h0C] = 16'h5045; ram[8'h0D] = 16'h1046;
        ram[8'h0E] = 16'h9009; ram[8'h0F] = 16'h2000; ram[8'h10] = 16'h1147;
        ram[8'h11] = 16'h9013; ram[8'h12] = 16'hFF00; ram[8'h13] = 16'h5049;
        ram[8'h14] = 16'h2000; ram[8'h15] = 16'h504A; ram[8'h16] = 16'h4000;
        ram[8'h40] = 16'h770F; ram[8'h41] = 16'h0042; ram[8'h42] = 16'h0012;
        ram[8'h44] = 16'h0005; ram[8'h46] = 16'h0003; ram[8'h47] = 16'h0048;
        ram[8'h48] = 16'h0000; ram[8'h49] = 16'hABCD;
        for (int a = 0; a < 256; a++) mm[a] = ram[a];
        build_trace();

        repeat (3) @(negedge clk);
        // R1 reset state
        check(mem_addr == 8'h00, "R1", "reset mem_addr", {8'h00, mem_addr}, 16'h0);
        check(mem_we == 1'b0, "R1", "reset mem_we", {15'h0, mem_we}, 16'h0);
        check(halt == 1'b0, "R1", "reset halt", {15'h0, halt}, 16'h0);
        rst_n = 1'b1;

        for (int i = 0; i < q_addr.size(); i++) begin
            if (i == 1)
                check(mem_addr == 8'h05, "R1", "first fetch address",
                      {8'h00, mem_addr}, 16'h0005);
            check(mem_addr == q_addr[i], q_tag[i], $sformatf("cycle %0d mem_addr", i),
                  {8'h00, mem_addr}, {8'h00, q_addr[i]});
            check(mem_we == q_we[i], q_tag[i], $sformatf("cycle %0d mem_we", i),
                  {15'h0, mem_we}, {15'h0, q_we[i]});
            if (q_we[i])
                check(mem_wdata == q_wd[i], q_tag[i], $sformatf("cycle %0d mem_wdata", i),
                      mem_wdata, q_wd[i]);
            check(halt == q_halt[i], q_tag[i], $sformatf("cycle %0d halt", i),
                  {15'h0, halt}, {15'h0, q_halt[i]});
            @(negedge clk);
        end

        // R9 store result, R6 accumulator kept across load of X
        check(ram[8'h43] == 16'h00FD, "R9", "store of -3", ram[8'h43], 16'h00FD);
        check(ram[8'h45] == 16'h00FD, "R6", "acc after LDX", ram[8'h45], 16'h00FD);
        // R5 indirect load of zero, R9 overwrite of old word
        check(ram[8'h49] == 16'h0000, "R5", "indirect zero stored", ram[8'h49], 16'h0000);
        // R7 0 - 5 wraps
        check(ram[8'h4A] == 16'h00FB, "R7", "sub wrap", ram[8'h4A], 16'h00FB);
        // R10 halted core wrote nothing more
        check(halt == 1'b1, "R10", "halt held", {15'h0, halt}, 16'h1);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R2 watchdog expired actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule